// File: doc/BRIEF.md
# Pin Port with Per-Pin Interrupt Conditions

This block is a 32-pin general-purpose I/O port. Software reaches it through a plain register port: a byte address, a write strobe, write data and a read-data bus that follows the address within the same cycle. Each pin can be an output or an input, as its direction bit selects. The level on each pin can be read back at any time. Each pin also raises an interrupt when it meets a selected condition: low level, high level, rising edge or falling edge.

Pin inputs pass through a two-flop synchroniser. The synchronised sample feeds both the pad-level register and the condition detectors. An edge is detected by comparing the current synchronised sample with the one from the cycle before. A detected condition sets a sticky pending flag. Software clears the flag by writing a one to it. A per-pin enable decides whether a pending flag reaches the interrupt lines. There is one line for pins 0–15, one for pins 16–31, and one that is high when either of them is high.

The register port carries single-cycle control accesses with no back-pressure, so it is a plain strobe interface and not a valid/ready stream. A write completes in the clock edge where `bus_wr` is high. A read is combinational from `bus_addr`.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the output-value, direction, enable and both condition registers read zero. `pad_oe` is all zero, so every pin is an input. All three interrupt outputs are low.
- R2: The registers sit at these byte addresses: output value 0x00, direction 0x04, pad level 0x08, conditions for pins 0–15 0x0C, conditions for pins 16–31 0x10, interrupt enable 0x14, pending 0x18. Each writable register reads back what was last written to it. A read of any other address returns zero.
- R3: For every pin, `pad_oe` equals its direction bit (1 = output) and `pad_out` equals its output-value bit.
- R4: The pad-level register returns the value `pad_in` had two clock edges earlier, whatever the direction bits are. A write to address 0x08 changes no register.
- R5: The condition code of pin p is bits [2·(p mod 16)+1 : 2·(p mod 16)]. These bits are in the 0x0C register for pins 0–15 and in the 0x10 register for pins 16–31.
- R6: Code 0 is low level and code 1 is high level. A level condition sets the pending bit on every clock in which it holds, so the bit sets again right after a clear while the level persists.
- R7: Code 2 is rising edge and code 3 is falling edge. After a change on `pad_in`, the pending bit sets on the third rising clock edge. It sets only once for that change, and the opposite transition does not set it.
- R8: In the pending register, writing a 1 to a bit clears that bit and writing a 0 leaves it unchanged. Writing all ones clears every bit whose condition does not hold in that same cycle. A pending bit stays set until it is cleared.
- R9: If a condition sets a pending bit in the same cycle that a write clears it, the bit stays set.
- R10: `irq_lo` is high when some pin in 0–15 has both its pending and enable bits set. `irq_hi` does the same for pins 16–31. `irq_any` is the OR of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Level on the pins, asynchronous |
| pad_out | output | 32 | Value driven on pins set as outputs |
| pad_oe | output | 32 | Output enable per pin, 1 = drive |
| irq_lo | output | 1 | Interrupt for pins 0–15 |
| irq_hi | output | 1 | Interrupt for pins 16–31 |
| irq_any | output | 1 | OR of both interrupt lines |

## Verification
The bench sweeps every pin through all four condition codes. A field placed at the wrong bit position, or in the wrong half register, then shows up as a flag set on the wrong pin or on the wrong interrupt line. Right after a clear-all write, it checks that a level condition that still holds leaves the flag set. A design that let the clear win would show the flag dropping for one cycle. It checks that an edge sets the flag only once and only in its own direction. A detector that looks at the raw pad, or that does not keep the previous sample, would either set again after the clear or miss the edge. It also checks the two-edge delay on the pad-level register, partial and zero clear writes, and a write to the read-only address, which must leave every register unchanged.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 5;

  typedef enum logic [1:0] {
    COND_LOW  = 2'd0,
    COND_HIGH = 2'd1,
    COND_RISE = 2'd2,
    COND_FALL = 2'd3
  } cond_e;

  localparam logic [ADDR_W-1:0] OFF_DOUT   = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_DIR    = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_PAD    = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_CFG_LO = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_CFG_HI = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_EN     = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_PEND   = 5'h18;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] meta_q, sync_q, prev_q;
  logic [1:0]   warm_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  // counts the edges since reset so the latency check only starts once both stages hold real samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm_cnt <= '0;
    else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
  end

  assign q      = sync_q;
  assign q_prev = prev_q;

  // R4
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_cnt == 2'd2) |-> (sync_q == $past(d, 2)));
endmodule

// File: rtl/gpio_cond_detect.sv
module gpio_cond_detect
  import gpio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]   lvl,
  input  logic [W-1:0]   lvl_prev,
  input  logic [2*W-1:0] cond,
  output logic [W-1:0]   hit
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    cond_e code;
    assign code = cond_e'(cond[2*i +: 2]);
    always_comb begin
      unique case (code)
        COND_LOW:  hit[i] = ~lvl[i];
        COND_HIGH: hit[i] = lvl[i];
        COND_RISE: hit[i] = lvl[i] & ~lvl_prev[i];
        COND_FALL: hit[i] = ~lvl[i] & lvl_prev[i];
        default:   hit[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pending.sv
module gpio_pending #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend
);
  logic [W-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | set;
  end

  assign pend = pend_q;

  // R8
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((pend_q & $past(set)) == $past(set)));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq_lo,
  output logic              irq_hi,
  output logic              irq_any
);
  localparam int HALF  = NPINS / 2;
  localparam int CFG_W = 2 * HALF;

  logic [NPINS-1:0] dout_q, dir_q, en_q;
  logic [CFG_W-1:0] cfg_lo_q, cfg_hi_q;
  logic [NPINS-1:0] lvl, lvl_prev, hit, pend, pend_clr, live;

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q   <= '0;
      dir_q    <= '0;
      en_q     <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
    end else if (bus_wr) begin
      unique case (bus_addr)
        OFF_DOUT:   dout_q   <= bus_wdata;
        OFF_DIR:    dir_q    <= bus_wdata;
        OFF_EN:     en_q     <= bus_wdata;
        OFF_CFG_LO: cfg_lo_q <= bus_wdata[CFG_W-1:0];
        OFF_CFG_HI: cfg_hi_q <= bus_wdata[CFG_W-1:0];
        default: ;
      endcase
    end
  end

  assign pend_clr = (bus_wr && bus_addr == OFF_PEND) ? bus_wdata : '0;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      (pad_in),
    .q      (lvl),
    .q_prev (lvl_prev)
  );

  gpio_cond_detect #(.W(NPINS)) u_detect (
    .lvl      (lvl),
    .lvl_prev (lvl_prev),
    .cond     ({cfg_hi_q, cfg_lo_q}),
    .hit      (hit)
  );

  gpio_pending #(.W(NPINS)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (hit),
    .clr   (pend_clr),
    .pend  (pend)
  );

  // read mux
  always_comb begin
    unique case (bus_addr)
      OFF_DOUT:   bus_rdata = dout_q;
      OFF_DIR:    bus_rdata = dir_q;
      OFF_PAD:    bus_rdata = lvl;
      OFF_CFG_LO: bus_rdata = NPINS'(cfg_lo_q);
      OFF_CFG_HI: bus_rdata = NPINS'(cfg_hi_q);
      OFF_EN:     bus_rdata = en_q;
      OFF_PEND:   bus_rdata = pend;
      default:    bus_rdata = '0;
    endcase
  end

  assign pad_out = dout_q;
  assign pad_oe  = dir_q;

  assign live    = pend & en_q;
  assign irq_lo  = |live[HALF-1:0];
  assign irq_hi  = |live[NPINS-1:HALF];
  assign irq_any = irq_lo | irq_hi;

  // R10
  irq_lo_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> (en_q[HALF-1:0] != '0));

  // R10
  irq_hi_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> (en_q[NPINS-1:HALF] != '0));

  // R4
  pad_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_PAD) |=> ($stable(dout_q) && $stable(dir_q) &&
      $stable(en_q) && $stable(cfg_lo_q) && $stable(cfg_hi_q)));
endmodule

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;
  localparam logic [4:0] A_DOUT = 5'h00, A_DIR = 5'h04, A_PAD = 5'h08,
                         A_CLO = 5'h0C, A_CHI = 5'h10, A_EN = 5'h14,
                         A_PEND = 5'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq_lo, irq_hi, irq_any;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gpio_irq_port i_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi),
    .irq_any(irq_any)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_irq(input string tag, input int p, input logic bitv);
    check({tag, " irq_lo"},  {31'd0, irq_lo},  {31'd0, (p < 16) && bitv});
    check({tag, " irq_hi"},  {31'd0, irq_hi},  {31'd0, (p >= 16) && bitv});
    check({tag, " irq_any"}, {31'd0, irq_any}, {31'd0, bitv});
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    n_fail++;
    $display("FAIL watchdog: got cycle %0d expected end before 150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(A_DOUT, v); check("R1 dout", v, '0);
    rd(A_DIR, v);  check("R1 dir", v, '0);
    rd(A_EN, v);   check("R1 enable", v, '0);
    rd(A_CLO, v);  check("R1 cfg lo", v, '0);
    rd(A_CHI, v);  check("R1 cfg hi", v, '0);
    check("R1 pad_oe", pad_oe, '0);
    check("R1 irq", {29'd0, irq_lo, irq_hi, irq_any}, '0);
    // R6 with reset codes (low level) and pads low, every pin pends
    idle(3);
    rd(A_PEND, v); check("R6 low level after reset", v, 32'hFFFF_FFFF);

    // R2 readback, R3 pins
    wr(A_DOUT, 32'hA5A5_0F0F); wr(A_DIR, 32'h0FF0_1234); wr(A_EN, 32'h8000_0001);
    wr(A_CLO, 32'h1357_9BDF);  wr(A_CHI, 32'h2468_ACE0);
    rd(A_DOUT, v); check("R2 dout", v, 32'hA5A5_0F0F);
    rd(A_DIR, v);  check("R2 dir", v, 32'h0FF0_1234);
    rd(A_EN, v);   check("R2 enable", v, 32'h8000_0001);
    rd(A_CLO, v);  check("R2 cfg lo", v, 32'h1357_9BDF);
    rd(A_CHI, v);  check("R2 cfg hi", v, 32'h2468_ACE0);
    rd(5'h1C, v);  check("R2 unmapped", v, '0);
    check("R3 pad_out", pad_out, 32'hA5A5_0F0F);
    check("R3 pad_oe", pad_oe, 32'h0FF0_1234);

    // R4 latency and direction independence
    pad_in = 32'hDEAD_BEEF;
    @(negedge clk); rd(A_PAD, v); check("R4 pad after 1 edge", v, '0);
    @(negedge clk); rd(A_PAD, v); check("R4 pad after 2 edges", v, 32'hDEAD_BEEF);
    wr(A_PAD, 32'h1234_5678);
    rd(A_PAD, v);  check("R4 pad after write", v, 32'hDEAD_BEEF);
    rd(A_DOUT, v); check("R4 dout kept", v, 32'hA5A5_0F0F);
    rd(A_DIR, v);  check("R4 dir kept", v, 32'h0FF0_1234);
    rd(A_CLO, v);  check("R4 cfg lo kept", v, 32'h1357_9BDF);

    // R8 partial clears: every pin rising edge, then all pads high
    wr(A_EN, '0); wr(A_DIR, '0);
    pad_in = '0; wr(A_CLO, 32'hAAAA_AAAA); wr(A_CHI, 32'hAAAA_AAAA);
    idle(4); wr(A_PEND, 32'hFFFF_FFFF);
    rd(A_PEND, v); check("R8 clear all", v, '0);
    pad_in = 32'hFFFF_FFFF; idle(4);
    rd(A_PEND, v); check("R7 rise all", v, 32'hFFFF_FFFF);
    wr(A_PEND, 32'h0000_FFFF);
    rd(A_PEND, v); check("R8 partial clear", v, 32'hFFFF_0000);
    wr(A_PEND, 32'h0000_0000);
    rd(A_PEND, v); check("R8 zero write", v, 32'hFFFF_0000);
    wr(A_PEND, 32'hFFFF_FFFF);
    rd(A_PEND, v); check("R8 all ones", v, '0);
    pad_in = '0; idle(4);
    rd(A_PEND, v); check("R7 falling not caught by rising", v, '0);

    // R5 R6 R7 R9 R10 sweep over pins and codes
    for (int p = 0; p < 32; p++) begin
      for (int c = 0; c < 4; c++) begin
        logic [31:0] cfg, bitm;
        logic b;
        bitm = 32'd1 << p;
        cfg = 32'hAAAA_AAAA & ~(32'd3 << (2 * (p % 16)));
        cfg = cfg | (32'(c) << (2 * (p % 16)));
        if (p < 16) begin wr(A_CLO, cfg); wr(A_CHI, 32'hAAAA_AAAA); end
        else        begin wr(A_CHI, cfg); wr(A_CLO, 32'hAAAA_AAAA); end
        wr(A_EN, bitm);
        wr(A_PEND, 32'hFFFF_FFFF);
        // R9 a holding low level survives the clear
        b = (c == 0);
        rd(A_PEND, v); check($sformatf("R9 R5 pin %0d code %0d idle", p, c), v, b ? bitm : '0);
        chk_irq("R10 idle", p, b);
        pad_in = bitm; idle(4);
        b = (c != 3);
        rd(A_PEND, v); check($sformatf("R7 R6 pin %0d code %0d after rise", p, c), v, b ? bitm : '0);
        chk_irq("R10 rise", p, b);
        wr(A_PEND, 32'hFFFF_FFFF);
        b = (c == 1);
        rd(A_PEND, v); check($sformatf("R6 pin %0d code %0d high held", p, c), v, b ? bitm : '0);
        chk_irq("R10 high", p, b);
        pad_in = '0; idle(4);
        b = (c != 2);
        rd(A_PEND, v); check($sformatf("R7 R6 pin %0d code %0d after fall", p, c), v, b ? bitm : '0);
        chk_irq("R10 fall", p, b);
      end
    end

    // R10 masked pending raises nothing
    wr(A_EN, '0);
    rd(A_PEND, v); check("R10 pending present", v != 0, 32'd1);
    check("R10 masked", {31'd0, irq_any}, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule